// File: doc/BRIEF.md
# System Configuration Register Block with Write Lock

This block holds a handful of 32-bit system configuration registers on a simple single-cycle register bus. Two of them are protected: the device configuration register and the clock control register. A write to either takes effect only when it is the first bus access after the unlock key has been written to the lock register. Any bus access consumes the unlock, whatever its address and whether it reads or writes. Software therefore writes the key once for every protected write.

The device configuration register drives a coprocessor enable output. It also produces a software reset: software sets the reset bit and then clears it with a second unlocked write, and the clearing emits a one-cycle system reset pulse. Two bits of the clock control register select the serial baud clock source and enable the USB host clock. The power state, halt and standby registers are plain read/write storage with no side effects. A protected write that arrives without a valid unlock is dropped and raises a sticky denial flag.

Top module: `syscon_ctrl`

## Requirements
- R1: After the asynchronous reset, every register reads zero, the block is locked (the lock register at 0xC0 reads 0), and all outputs are low.
- R2: The registers at 0x00, 0x08 and 0x0C accept writes whether the block is locked or not, and read back the last value written. A read of an unmapped offset returns zero. When no read is in progress, rdata_o is zero.
- R3: Writing exactly 0x000000AA to 0xC0 unlocks the block. While the block is unlocked, a read of 0xC0 returns 1, and it returns 0 otherwise.
- R4: The first bus access after the key write relocks the block, whatever its address and whether it reads or writes. An idle cycle leaves the lock state unchanged. If that first access is a write to a protected register (0x80 or 0x04), the write takes effect.
- R5: A write to 0x80 or 0x04 while the block is locked leaves the register unchanged and sets denied_o. denied_o stays high until reset.
- R6: cop_en_o equals bit 23 of the device configuration register (0x80), starting in the cycle after the accepted write.
- R7: Bit 31 of 0x80 reads back the value last written. sys_rst_o is high for exactly one cycle, the cycle after an accepted write changes bit 31 from 1 to 0. Setting the bit, or writing 0 over 0, gives no pulse.
- R8: uart_clk_sel_o equals bit 29 and usb_clk_en_o equals bit 28 of the clock control register (0x04), starting in the cycle after the accepted write.
- R9: A write of any value other than the key to 0xC0 leaves the block locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i is high and we_i is low |
| cop_en_o | output | 1 | Coprocessor enable |
| sys_rst_o | output | 1 | One-cycle software reset pulse |
| uart_clk_sel_o | output | 1 | Serial baud clock source select |
| usb_clk_en_o | output | 1 | USB host clock enable |
| denied_o | output | 1 | Sticky flag: a protected write was refused |

## Verification
Read data is combinational. It is valid in the same cycle as the read request and reflects the lock state before that access consumes it. All register effects and level outputs change at the clock edge that samples the write, so the bench samples them at the following falling edge.

The reset pulse is high only between the edge that samples the clearing write and the next edge. The bench checks it at the first falling edge, and checks that it has gone low at the second. A behavioural reference model is updated on every rising edge and compared with every output at every falling edge. Inputs change just after the rising edge, so the comparison never races with the stimulus.

// File: rtl/syscon_pkg.sv
package syscon_pkg;
  localparam int NREG     = 5;
  localparam int IDX_PWR  = 0;
  localparam int IDX_CLK  = 1;
  localparam int IDX_HALT = 2;
  localparam int IDX_STBY = 3;
  localparam int IDX_DEV  = 4;
  // registers that need the unlock key
  localparam logic [NREG-1:0] PROT_MASK = 5'b10010;
endpackage

// File: rtl/syscon_decode.sv
module syscon_decode
  import syscon_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PWR_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] CLK_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] HALT_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] STBY_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] DEV_OFS  = 8'h80,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 8'hC0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   hit_o,
  output logic              lock_hit_o
);
  localparam logic [ADDR_W-1:0] OFS_TAB [NREG] =
    '{PWR_OFS, CLK_OFS, HALT_OFS, STBY_OFS, DEV_OFS};

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit_o[i] = (addr_i == OFS_TAB[i]);
  end

  assign lock_hit_o = (addr_i == LOCK_OFS);
endmodule

// File: rtl/syscon_lock.sv
module syscon_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic key_wr_i,
  input  logic prot_wr_i,
  output logic unlocked_o,
  output logic denied_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o <= 1'b0;
      denied_o   <= 1'b0;
    end else begin
      // one-shot: every access re-arms or drops the unlock
      if (access_i) unlocked_o <= key_wr_i;
      if (prot_wr_i && !unlocked_o) denied_o <= 1'b1;
    end
  end

  // R3
  key_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i |=> unlocked_o);
  // R4
  consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !key_wr_i) |=> !unlocked_o);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i |=> $stable(unlocked_o));
  // R5
  denied_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    denied_o |=> denied_o);
endmodule

// File: rtl/syscon_regfile.sv
module syscon_regfile
  import syscon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [NREG-1:0]              hit_i,
  input  logic                         unlocked_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
  logic [NREG-1:0] wen;

  for (genvar i = 0; i < NREG; i++) begin : g_wen
    if (PROT_MASK[i]) begin : g_prot
      assign wen[i] = wr_i && hit_i[i] && unlocked_i;
    end else begin : g_open
      assign wen[i] = wr_i && hit_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_o <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wen[i]) regs_o[i] <= wdata_i;
      end
    end
  end

  // R5
  locked_dev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_i[IDX_DEV] && !unlocked_i) |=> $stable(regs_o[IDX_DEV]));
  // R5
  locked_clk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_i[IDX_CLK] && !unlocked_i) |=> $stable(regs_o[IDX_CLK]));
  // R2
  open_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_i[IDX_HALT]) |=> regs_o[IDX_HALT] == $past(wdata_i));
endmodule

// File: rtl/syscon_rst_pulse.sv
module syscon_rst_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= level_i;
  end

  // falling edge of the stored bit, built from flops only
  assign pulse_o = last_q & ~level_i;

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/syscon_ctrl.sv
module syscon_ctrl
  import syscon_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] KEY      = 32'h0000_00AA,
  parameter logic [ADDR_W-1:0] PWR_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] CLK_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] HALT_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] STBY_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] DEV_OFS  = 8'h80,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 8'hC0,
  parameter int                COP_BIT  = 23,
  parameter int                RST_BIT  = 31,
  parameter int                UART_BIT = 29,
  parameter int                USB_BIT  = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cop_en_o,
  output logic              sys_rst_o,
  output logic              uart_clk_sel_o,
  output logic              usb_clk_en_o,
  output logic              denied_o
);
  logic [NREG-1:0]             hit;
  logic                        lock_hit;
  logic                        unlocked;
  logic                        wr;
  logic                        key_wr;
  logic                        prot_wr;
  logic [NREG-1:0][DATA_W-1:0] regs;

  assign wr      = req_i && we_i;
  assign key_wr  = wr && lock_hit && (wdata_i == KEY);
  assign prot_wr = wr && |(hit & PROT_MASK);

  syscon_decode #(
    .ADDR_W(ADDR_W), .PWR_OFS(PWR_OFS), .CLK_OFS(CLK_OFS), .HALT_OFS(HALT_OFS),
    .STBY_OFS(STBY_OFS), .DEV_OFS(DEV_OFS), .LOCK_OFS(LOCK_OFS)
  ) u_decode (
    .addr_i     (addr_i),
    .hit_o      (hit),
    .lock_hit_o (lock_hit)
  );

  syscon_lock u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .access_i   (req_i),
    .key_wr_i   (key_wr),
    .prot_wr_i  (prot_wr),
    .unlocked_o (unlocked),
    .denied_o   (denied_o)
  );

  syscon_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .hit_i      (hit),
    .unlocked_i (unlocked),
    .wdata_i    (wdata_i),
    .regs_o     (regs)
  );

  syscon_rst_pulse u_rst_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (regs[IDX_DEV][RST_BIT]),
    .pulse_o (sys_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      for (int i = 0; i < NREG; i++) begin
        if (hit[i]) rdata_o = rdata_o | regs[i];
      end
      if (lock_hit) rdata_o[0] = unlocked;
    end
  end

  assign cop_en_o       = regs[IDX_DEV][COP_BIT];
  assign uart_clk_sel_o = regs[IDX_CLK][UART_BIT];
  assign usb_clk_en_o   = regs[IDX_CLK][USB_BIT];

  // R6
  cop_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit[IDX_DEV] && unlocked) |=> cop_en_o == $past(wdata_i[COP_BIT]));
  // R7
  rst_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit[IDX_DEV] && unlocked && regs[IDX_DEV][RST_BIT] && !wdata_i[RST_BIT])
      |=> sys_rst_o);
  // R8
  clk_locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit[IDX_CLK] && !unlocked) |=> $stable({uart_clk_sel_o, usb_clk_en_o}));
  // R2
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0);
endmodule

// File: tb/syscon_ctrl_test.sv
module syscon_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cop_en, sys_rst, uart_sel, usb_en, denied;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syscon_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cop_en_o(cop_en), .sys_rst_o(sys_rst),
    .uart_clk_sel_o(uart_sel), .usb_clk_en_o(usb_en), .denied_o(denied)
  );

  // behavioural reference
  logic [31:0] m_pwr, m_clk, m_halt, m_stby, m_dev;
  logic        m_unl, m_den, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr <= 0; m_clk <= 0; m_halt <= 0; m_stby <= 0; m_dev <= 0;
      m_unl <= 0; m_den <= 0; m_rst <= 0;
    end else begin
      m_rst <= 1'b0;
      if (req) begin
        m_unl <= we && addr == 8'hC0 && wdata == 32'hAA;
        if (we) begin
          case (addr)
            8'h00: m_pwr  <= wdata;
            8'h08: m_halt <= wdata;
            8'h0C: m_stby <= wdata;
            8'h04: if (m_unl) m_clk <= wdata; else m_den <= 1'b1;
            8'h80: begin
              if (m_unl) begin
                m_dev <= wdata;
                if (m_dev[31] && !wdata[31]) m_rst <= 1'b1;
              end else m_den <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] model_rd();
    if (!(req && !we)) return 32'h0;
    case (addr)
      8'h00: return m_pwr;
      8'h04: return m_clk;
      8'h08: return m_halt;
      8'h0C: return m_stby;
      8'h80: return m_dev;
      8'hC0: return {31'h0, m_unl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R2/R3 model rdata", rdata, model_rd());
    check("R6 model cop_en", {31'h0, cop_en}, {31'h0, m_dev[23]});
    check("R7 model sys_rst", {31'h0, sys_rst}, {31'h0, m_rst});
    check("R8 model uart_sel", {31'h0, uart_sel}, {31'h0, m_clk[29]});
    check("R8 model usb_en", {31'h0, usb_en}, {31'h0, m_clk[28]});
    check("R5 model denied", {31'h0, denied}, {31'h0, m_den});
  end

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = w; addr = a; wdata = d;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
  endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    acc(1'b0, a, 32'h0);
    @(negedge clk);
    check(tag, rdata, exp);
  endtask
  task automatic idle();
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask
  task automatic outs(input logic [4:0] exp, input string tag);
    @(negedge clk);
    check(tag, {27'h0, cop_en, sys_rst, uart_sel, usb_en, denied}, {27'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    outs(5'b00000, "R1 outputs in reset");
    rst_n = 1'b1;
    rd(8'hC0, 32'h0, "R1 locked after reset");
    rd(8'h80, 32'h0, "R1 dev zero");
    rd(8'h04, 32'h0, "R1 clk zero");

    wr(8'h00, 32'hDEADBEEF); wr(8'h08, 32'h1234_5678); wr(8'h0C, 32'h0000_55AA);
    rd(8'h00, 32'hDEADBEEF, "R2 power readback");
    rd(8'h08, 32'h1234_5678, "R2 halt readback");
    rd(8'h0C, 32'h0000_55AA, "R2 standby readback");
    rd(8'h10, 32'h0, "R2 unmapped read");

    wr(8'h80, 32'h0080_0000); idle();
    outs(5'b00001, "R5 locked dev write refused, denied set");
    rd(8'h80, 32'h0, "R5 dev unchanged");

    wr(8'hC0, 32'hAA);
    rd(8'hC0, 32'h1, "R3 lock reads 1 when unlocked");
    rd(8'hC0, 32'h0, "R4 read consumed unlock");

    wr(8'hC0, 32'hAA); idle(); idle(); idle();
    rd(8'hC0, 32'h1, "R4 idle keeps unlock");

    wr(8'hC0, 32'hAA); wr(8'h80, 32'h0080_0000); idle();
    outs(5'b10001, "R6 cop_en after unlocked write");
    rd(8'h80, 32'h0080_0000, "R4 protected write after key");

    wr(8'hC0, 32'hAA); wr(8'h00, 32'h0); wr(8'h80, 32'h0); idle();
    outs(5'b10001, "R4 write to other reg consumed unlock");

    wr(8'hC0, 32'h55);
    rd(8'hC0, 32'h0, "R9 wrong key stays locked");
    wr(8'hC0, 32'hAA); wr(8'hC0, 32'h1AA);
    rd(8'hC0, 32'h0, "R9 non-key lock write relocks");

    wr(8'hC0, 32'hAA); wr(8'h80, 32'h8080_0000); idle();
    outs(5'b10001, "R7 no pulse on set");
    rd(8'h80, 32'h8080_0000, "R7 bit31 reads back");
    wr(8'hC0, 32'hAA); wr(8'h80, 32'h0080_0000); idle();
    outs(5'b11001, "R7 pulse on clear");
    outs(5'b10001, "R7 pulse one cycle only");
    wr(8'hC0, 32'hAA); wr(8'h80, 32'h0); idle();
    outs(5'b00001, "R6 cop_en cleared, R7 no pulse 0 to 0");

    wr(8'hC0, 32'hAA); wr(8'h04, 32'h3000_0000); idle();
    outs(5'b00111, "R8 both clock bits");
    wr(8'hC0, 32'hAA); wr(8'h04, 32'h1000_0000); idle();
    outs(5'b00011, "R8 usb only");
    wr(8'h04, 32'h2000_0000); idle();
    outs(5'b00011, "R8 locked clk write ignored");

    @(posedge clk); #1; rst_n = 1'b0;
    outs(5'b00000, "R1 async reset clears outputs");
    @(posedge clk); #1; rst_n = 1'b1;
    rd(8'h00, 32'h0, "R1 power cleared");
    idle();
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule